// File: doc/BRIEF.md
# Keyed Configuration Write Guard

This block keeps a small set of pad-routing selection bits safe from stray software writes. A lock flag sits between the bus and an 8-bit commit mask. The flag is cleared only by writing one fixed 32-bit key value, and the commit mask can be rewritten only while the flag is clear. Writes to the 8-bit alternate-function selection register are then applied bit by bit. Only the positions whose commit bit is set take the new value.

The block sits on a plain memory-mapped register bus. The bus has a byte address, a write enable with write data, and a read strobe. Read data is registered: it appears in the cycle after the strobe and is zero in any cycle after a cycle with no strobe. The bus has no back-pressure, and every access completes in one cycle. The current selection value drives the pad logic directly.

Top module: `keyed_cfg_guard`

## Requirements
- R1: A write of exactly 0x0ACCE551 to the lock register (byte offset 0x520) clears the lock flag on the clock edge that carries the write.
- R2: A write of any other value to the lock register sets the lock flag on the clock edge that carries the write.
- R3: A read of the lock register returns 1 while locked and 0 while unlocked, in bit 0, with all higher bits zero.
- R4: A write to the commit register (byte offset 0x524) is stored only while unlocked, and only write-data bits 7:0 are kept. A read returns the stored value zero-extended to 32 bits.
- R5: A write to the selection register (byte offset 0x420) changes only the bit positions whose commit bit is 1, and the other bits keep their value. A read returns the value zero-extended, and `alt_sel` shows the new value in the cycle after the write edge.
- R6: After reset the block is locked, the commit register holds 0xFF and the selection register holds 0x00.
- R7: A write to any other offset changes no state, and a read of any other offset returns zero.
- R8: Read data is registered. `bus_rdata` carries the addressed value in the cycle after a cycle with `bus_rd` high, and it is zero in the cycle after a cycle with `bus_rd` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| alt_sel | output | 8 | Current alternate-function selection to the pads |

## Verification
The hardest state to reach from the ports is a selection register that holds a mix of bits: some set while they were committed and later frozen by a narrowed commit mask. Reaching it takes the full sequence of unlock, commit rewrite, optional relock and selection write, all in order. The random stream therefore mixes correct keys, near-miss keys, commit writes and selection writes with different weights, so the flag toggles often and many partial masks build up. Directed cases add a near-miss key, a commit write while locked, and writes to unmapped offsets.

// File: rtl/guard_pkg.sv
package guard_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int SEL_W  = 8;
  localparam logic [ADDR_W-1:0] OFS_SEL    = 12'h420;
  localparam logic [ADDR_W-1:0] OFS_LOCK   = 12'h520;
  localparam logic [ADDR_W-1:0] OFS_COMMIT = 12'h524;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0ACC_E551;
  localparam logic [SEL_W-1:0]  COMMIT_RST = '1;
  localparam logic [SEL_W-1:0]  SEL_RST    = '0;

  typedef struct packed {
    logic lock;
    logic commit;
    logic sel;
  } reg_hit_t;
endpackage

// File: rtl/guard_decode.sv
module guard_decode
  import guard_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output reg_hit_t          hit
);
  always_comb begin
    hit        = '0;
    hit.lock   = (addr == OFS_LOCK);
    hit.commit = (addr == OFS_COMMIT);
    hit.sel    = (addr == OFS_SEL);
  end
endmodule

// File: rtl/guard_lock.sv
module guard_lock
  import guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  locked <= 1'b1;
    else if (we) locked <= (wdata != UNLOCK_KEY);
  end
endmodule

// File: rtl/guard_masked_reg.sv
module guard_masked_reg #(
  parameter int         W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wmask,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                q[b] <= RST_VAL[b];
      else if (we && wmask[b])   q[b] <= wdata[b];
    end
  end
endmodule

// File: rtl/guard_readmux.sv
module guard_readmux
  import guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  reg_hit_t          hit,
  input  logic              locked,
  input  logic [SEL_W-1:0]  commit,
  input  logic [SEL_W-1:0]  sel,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - SEL_W;
  logic [DATA_W-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (hit.lock)   rd_val = {{(DATA_W-1){1'b0}}, locked};
    if (hit.commit) rd_val = {{PAD_W{1'b0}}, commit};
    if (hit.sel)    rd_val = {{PAD_W{1'b0}}, sel};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd ? rd_val : '0;
  end
endmodule

// File: rtl/keyed_cfg_guard.sv
module keyed_cfg_guard
  import guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic [7:0]        alt_sel
);
  reg_hit_t          hit;
  logic              lock_q;
  logic [SEL_W-1:0]  commit_q;
  logic [SEL_W-1:0]  sel_q;

  guard_decode u_dec (.addr(bus_addr), .hit(hit));

  guard_lock u_lock (
    .clk(clk), .rst_n(rst_n),
    .we(bus_wr && hit.lock), .wdata(bus_wdata), .locked(lock_q)
  );

  // commit mask: every bit writable only while the flag is clear
  guard_masked_reg #(.W(SEL_W), .RST_VAL(COMMIT_RST)) u_commit (
    .clk(clk), .rst_n(rst_n),
    .we(bus_wr && hit.commit), .wmask({SEL_W{~lock_q}}),
    .wdata(bus_wdata[SEL_W-1:0]), .q(commit_q)
  );

  // selection register: per-bit gating by the commit mask
  guard_masked_reg #(.W(SEL_W), .RST_VAL(SEL_RST)) u_sel (
    .clk(clk), .rst_n(rst_n),
    .we(bus_wr && hit.sel), .wmask(commit_q),
    .wdata(bus_wdata[SEL_W-1:0]), .q(sel_q)
  );

  guard_readmux u_rd (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .hit(hit),
    .locked(lock_q), .commit(commit_q), .sel(sel_q), .rdata(bus_rdata)
  );

  assign alt_sel = sel_q;
endmodule

// File: rtl/keyed_cfg_guard_chk.sv
module keyed_cfg_guard_chk
  import guard_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] bus_addr,
  input logic        bus_wr,
  input logic [31:0] bus_wdata,
  input logic        bus_rd,
  input logic [31:0] bus_rdata,
  input logic [7:0]  alt_sel,
  input logic        locked,
  input logic [7:0]  commit
);
  AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_LOCK && bus_wdata == UNLOCK_KEY) |=> !locked); // R1
  AST_BADKEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_LOCK && bus_wdata != UNLOCK_KEY) |=> locked); // R2
  AST_LOCK_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_LOCK) |=> bus_rdata == {31'b0, $past(locked)}); // R3
  AST_COMMIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_COMMIT && locked) |=> $stable(commit)); // R4
  AST_SEL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_SEL) |=> ((alt_sel ^ $past(alt_sel)) & ~$past(commit)) == 8'h00); // R5
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == OFS_SEL) |=> $stable(alt_sel)); // R7
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == 32'h0); // R8
endmodule

bind keyed_cfg_guard keyed_cfg_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .alt_sel(alt_sel), .locked(lock_q), .commit(commit_q)
);

// File: tb/keyed_cfg_guard_test.sv
module keyed_cfg_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'h0ACC_E551;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  alt_sel;

  int checks = 0;
  int errors = 0;
  bit m_locked;
  logic [7:0] m_commit, m_sel;

  keyed_cfg_guard uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .alt_sel(alt_sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [11:0] a);
    case (a)
      12'h520: return {31'b0, m_locked};
      12'h524: return {24'b0, m_commit};
      12'h420: return {24'b0, m_sel};
      default: return 32'h0;
    endcase
  endfunction

  function automatic void model_write(input logic [11:0] a, input logic [31:0] d);
    case (a)
      12'h520: m_locked = (d != KEY);
      12'h524: if (!m_locked) m_commit = d[7:0];
      12'h420: m_sel = (m_sel & ~m_commit) | (d[7:0] & m_commit);
      default: ;
    endcase
  endfunction

  // inputs change at negedge; one posedge applies them; checked at next negedge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
    model_write(a, d);
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R5 alt_sel", {24'b0, alt_sel}, {24'b0, m_sel});
  endtask

  task automatic rd(input string req, input logic [11:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(req, bus_rdata, model_read(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_locked = 1'b1; m_commit = 8'hFF; m_sel = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R6 reset state
    rd("R6 lock after reset", 12'h520);
    rd("R6 commit after reset", 12'h524);
    rd("R6 sel after reset", 12'h420);
    chk("R6 alt_sel after reset", {24'b0, alt_sel}, 32'h0);
    // R8 idle read data
    @(negedge clk);
    chk("R8 rdata idle", bus_rdata, 32'h0);
    // R4 commit write while locked is ignored
    wr(12'h524, 32'h0000_000F);
    rd("R4 commit locked", 12'h524);
    // R1 unlock, R4 commit stores low byte only
    wr(12'h520, KEY);
    rd("R1 unlocked", 12'h520);
    wr(12'h524, 32'hABCD_12F0);
    rd("R4 commit low byte", 12'h524);
    // R5 masked selection write
    wr(12'h420, 32'h0000_00FF);
    rd("R5 sel masked", 12'h420);
    // R2 near-miss key locks
    wr(12'h520, 32'h0ACC_E550);
    rd("R2 near-miss locks", 12'h520);
    wr(12'h524, 32'h0000_00FF);
    rd("R4 commit frozen", 12'h524);
    // R7 unmapped offsets
    wr(12'h528, 32'hFFFF_FFFF);
    wr(12'h418, 32'hFFFF_FFFF);
    rd("R7 unmapped read 0x528", 12'h528);
    rd("R7 unmapped read 0x41C", 12'h41C);
    rd("R7 sel unchanged", 12'h420);
    rd("R7 commit unchanged", 12'h524);
    rd("R3 lock readback", 12'h520);
    // random mix
    for (int i = 0; i < 400; i++) begin
      int pick;
      pick = $urandom_range(0, 9);
      case (pick)
        0, 1: wr(12'h520, ($urandom_range(0, 1) != 0) ? KEY : (KEY ^ (32'h1 << $urandom_range(0, 31))));
        2, 3: wr(12'h524, $urandom);
        4, 5: wr(12'h420, $urandom);
        6:    wr({$urandom_range(0, 15), 8'h00} | 12'h004, $urandom);
        7:    rd("R3 lock random", 12'h520);
        8:    rd("R4 commit random", 12'h524);
        default: rd("R5 sel random", 12'h420);
      endcase
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule